// File: doc/BRIEF.md
# Pen Interrupt and Power-Mode Controller

This block sits beside the serial sequencer of a resistive touch digitizer. It owns two things: the active-low pen interrupt that tells a host processor the panel is being touched, and the power state of the converter between transfers. Its only configuration is a two-bit power code. The sequencer writes this code whenever a control word delivers new power bits. The code sets two policies. One decides whether the converter sleeps between conversions or stays awake. The other decides whether touches may raise the interrupt.

The sequencer also reports when a start bit is seen, and it strobes once for each falling edge of the serial clock. The controller counts those edges to find the wake point and the end of conversion. A raw touch-detect level comes in from the panel. It must be held for a programmable number of clock cycles before the interrupt goes low. The controller also drives the ground-side Y switch that keeps the panel biased for touch detection while the converter sleeps.

Internally a sequence machine has three states. `PH_IDLE` means no transfer is in progress. `PH_CMD` covers the span from the start bit up to the wake edge. `PH_CONV` covers the span from the wake edge to the end of conversion. The transitions are: PH_IDLE→PH_CMD on a start strobe; PH_CMD→PH_CONV on the WAKE_EDGE-th falling edge; PH_CONV→PH_IDLE on the DONE_EDGE-th falling edge; PH_CMD→PH_CMD and PH_CONV→PH_CMD on a new start strobe, which restarts the edge count.

Top module: `pen_pm_ctrl`

## Requirements
- R1: While reset is applied and right after it, the power code is 2'b10, the interrupt output is high, the converter reports powered and the ground-side Y switch is off.
- R2: With code 2'b00 in PH_IDLE the converter is powered down, the ground-side Y switch is on, and touches may raise the interrupt.
- R3: With code 2'b01 in PH_IDLE the converter is powered down, the ground-side Y switch is off, and no touch ever drives the interrupt low.
- R4: With code 2'b10 the converter stays powered in every state and touches may raise the interrupt; a touch counts from the first clock edge after the code is written.
- R5: With code 2'b11 the converter stays powered, the Y switch stays off, and no touch drives the interrupt low.
- R6: With the interrupt enabled, a touch held for TOUCH_DLY consecutive clock edges drives the interrupt low on the last of them. A touch released earlier never drives it low. A release after assertion returns it high on the next edge.
- R7: From the start strobe until the end of conversion, the interrupt never newly goes low. If it is already low at the start, it stays low until the WAKE_EDGE-th falling edge and then goes high.
- R8: In the power-down codes the converter stays in its previous power state from the start strobe until the WAKE_EDGE-th falling edge, and is powered from that edge on.
- R9: On the DONE_EDGE-th falling edge the block returns to PH_IDLE. It applies the power code most recently written. The touch count restarts from zero, so a held touch asserts the interrupt TOUCH_DLY edges later.
- R10: A start strobe during a transfer restarts the falling-edge count from zero, and the power state is held through the new PH_CMD.
- R11: Falling-edge strobes in PH_IDLE are ignored. They change no output and do not advance the wake or end-of-conversion count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle strobe: start bit detected |
| dclk_fall_i | input | 1 | One-cycle strobe per serial-clock falling edge |
| pd_wr_i | input | 1 | One-cycle strobe: load a new power code |
| pd_i | input | 2 | Power code; bit 1 keeps the converter awake, bit 0 masks the interrupt |
| touch_i | input | 1 | Raw touch-detect level, high while touched |
| pen_irq_n_o | output | 1 | Active-low pen interrupt |
| powered_o | output | 1 | High while the converter is powered |
| ymin_gnd_o | output | 1 | High while the ground-side Y switch is on |

## Verification
Several properties are checked on every cycle. The interrupt can fall only right after a sampled touch, and never while a transfer is running. The converter is always powered in PH_CONV. The Y switch is on only while the converter is asleep. A settled idle state with a masking code keeps the interrupt high. An always-on code keeps the converter awake. The edge count never passes its limit. Exact timing can only be shown by the bench's scenarios: the edge on which the interrupt falls after a touch, the wake and end-of-conversion edges, the restart of the count by a second start strobe, the handover to a code written mid-conversion, and the fact that idle falling-edge strobes are ignored.

// File: rtl/pen_pm_pkg.sv
package pen_pm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_CONV = 2'd2
    } phase_e;

    typedef struct packed {
        logic sleep_idle;   // power down while no transfer runs
        logic irq_en;       // touches may raise the interrupt
        logic ymin_sleep;   // ground-side Y switch on while asleep
    } pm_policy_t;

    localparam logic [1:0] PD_RESET = 2'b10;

    function automatic pm_policy_t decode_pd(input logic [1:0] pd);
        pm_policy_t p;
        unique case (pd)
            2'b00:   p = '{sleep_idle: 1'b1, irq_en: 1'b1, ymin_sleep: 1'b1};
            2'b01:   p = '{sleep_idle: 1'b1, irq_en: 1'b0, ymin_sleep: 1'b0};
            2'b10:   p = '{sleep_idle: 1'b0, irq_en: 1'b1, ymin_sleep: 1'b0};
            default: p = '{sleep_idle: 1'b0, irq_en: 1'b0, ymin_sleep: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pen_pm_mode.sv
module pen_pm_mode
    import pen_pm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [1:0] pd_i,
    output logic [1:0] pd_o,
    output pm_policy_t policy_o
);

    logic [1:0] pd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pd_q <= PD_RESET;
        end else if (wr_i) begin
            pd_q <= pd_i;
        end
    end

    always_comb begin
        pd_o     = pd_q;
        policy_o = decode_pd(pd_q);
    end

endmodule

// File: rtl/pen_pm_seq.sv
module pen_pm_seq
    import pen_pm_pkg::*;
#(
    parameter int WAKE_EDGE = 4,
    parameter int DONE_EDGE = 20
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   fall_i,
    input  logic   sleep_idle_i,
    output phase_e phase_o,
    output phase_e phase_nx_o,
    output logic   powered_o
);

    localparam int            EW     = $clog2(DONE_EDGE + 1);
    localparam logic [EW-1:0] WAKE_C = EW'(WAKE_EDGE);
    localparam logic [EW-1:0] DONE_C = EW'(DONE_EDGE);

    phase_e        state_q, state_d;
    logic [EW-1:0] ecnt_q, ecnt_d, ecnt_inc;
    logic          hold_q;

    assign ecnt_inc = ecnt_q + EW'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            ecnt_q  <= '0;
            hold_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            ecnt_q  <= ecnt_d;
            hold_q  <= powered_o;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        ecnt_d  = ecnt_q;
        unique case (state_q)
            PH_IDLE: begin
                if (start_i) begin
                    state_d = PH_CMD;
                    ecnt_d  = '0;
                end
            end
            PH_CMD: begin
                if (start_i) begin
                    ecnt_d = '0;
                end else if (fall_i) begin
                    ecnt_d = ecnt_inc;
                    if (ecnt_inc == WAKE_C) state_d = PH_CONV;
                end
            end
            PH_CONV: begin
                if (start_i) begin
                    state_d = PH_CMD;
                    ecnt_d  = '0;
                end else if (fall_i) begin
                    if (ecnt_inc == DONE_C) begin
                        state_d = PH_IDLE;
                        ecnt_d  = '0;
                    end else begin
                        ecnt_d = ecnt_inc;
                    end
                end
            end
            default: begin
                state_d = PH_IDLE;
                ecnt_d  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        phase_o    = state_q;
        phase_nx_o = state_d;
        unique case (state_q)
            PH_IDLE: powered_o = !sleep_idle_i;
            PH_CMD:  powered_o = hold_q;
            PH_CONV: powered_o = 1'b1;
            default: powered_o = 1'b1;
        endcase
    end

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ecnt_q <= DONE_C);

    p_idle_fall_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_IDLE && !start_i) |=> (state_q == PH_IDLE && ecnt_q == '0));

endmodule

// File: rtl/pen_pm_touch.sv
module pen_pm_touch
    import pen_pm_pkg::*;
#(
    parameter int TOUCH_DLY = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   touch_i,
    input  logic   arm_i,
    input  phase_e phase_nx_i,
    output logic   pen_n_o
);

    localparam int            TW    = $clog2(TOUCH_DLY + 1);
    localparam logic [TW-1:0] TFULL = TW'(TOUCH_DLY - 1);

    logic [TW-1:0] tcnt_q, tcnt_d;
    logic          lat_q, lat_d;
    logic          live;

    assign live = touch_i && arm_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q <= '0;
            lat_q  <= 1'b0;
        end else begin
            tcnt_q <= tcnt_d;
            lat_q  <= lat_d;
        end
    end

    always_comb begin
        if (!live)                tcnt_d = '0;
        else if (tcnt_q == TFULL) tcnt_d = tcnt_q;
        else                      tcnt_d = tcnt_q + TW'(1);
    end

    always_comb begin
        unique case (phase_nx_i)
            PH_CONV: lat_d = 1'b0;
            PH_CMD:  lat_d = lat_q;
            PH_IDLE: lat_d = live && (lat_q || tcnt_q == TFULL);
            default: lat_d = 1'b0;
        endcase
        pen_n_o = !lat_q;
    end

    p_pen_needs_touch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_q) |-> $past(touch_i));

    p_pen_needs_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lat_q) |-> $past(arm_i));

endmodule

// File: rtl/pen_pm_ctrl.sv
module pen_pm_ctrl
    import pen_pm_pkg::*;
#(
    parameter int TOUCH_DLY = 4,
    parameter int WAKE_EDGE = 4,
    parameter int DONE_EDGE = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       dclk_fall_i,
    input  logic       pd_wr_i,
    input  logic [1:0] pd_i,
    input  logic       touch_i,
    output logic       pen_irq_n_o,
    output logic       powered_o,
    output logic       ymin_gnd_o
);

    logic [1:0] pd_cur;
    pm_policy_t pol;
    phase_e     phase, phase_nx;
    logic       arm;

    pen_pm_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (pd_wr_i),
        .pd_i     (pd_i),
        .pd_o     (pd_cur),
        .policy_o (pol)
    );

    pen_pm_seq #(
        .WAKE_EDGE (WAKE_EDGE),
        .DONE_EDGE (DONE_EDGE)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .fall_i       (dclk_fall_i),
        .sleep_idle_i (pol.sleep_idle),
        .phase_o      (phase),
        .phase_nx_o   (phase_nx),
        .powered_o    (powered_o)
    );

    assign arm = (phase == PH_IDLE) && pol.irq_en;

    pen_pm_touch #(
        .TOUCH_DLY (TOUCH_DLY)
    ) u_touch (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_i    (touch_i),
        .arm_i      (arm),
        .phase_nx_i (phase_nx),
        .pen_n_o    (pen_irq_n_o)
    );

    assign ymin_gnd_o = !powered_o && pol.ymin_sleep;

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pen_irq_n_o && powered_o && !ymin_gnd_o));

    p_ymin_asleep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ymin_gnd_o |-> !powered_o);

    p_irq_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && $past(phase == PH_IDLE) && pd_cur[0] && $past(pd_cur[0]))
        |-> pen_irq_n_o);

    p_always_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && $past(phase == PH_IDLE) && pd_cur[1] && $past(pd_cur[1]))
        |-> powered_o);

    p_no_new_pen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) != PH_IDLE) |-> !$fell(pen_irq_n_o));

    p_conv_awake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONV) |-> powered_o);

endmodule

// File: tb/tb_pen_pm_ctrl.sv
module tb_pen_pm_ctrl;

    localparam int TD = 4;
    localparam int WE = 4;
    localparam int DE = 20;

    logic clk = 1'b0;
    logic rst_n;
    logic start_i, dclk_fall_i, pd_wr_i, touch_i;
    logic [1:0] pd_i;
    logic pen_irq_n_o, powered_o, ymin_gnd_o;

    always #5 clk = ~clk;

    pen_pm_ctrl #(.TOUCH_DLY(TD), .WAKE_EDGE(WE), .DONE_EDGE(DE)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dclk_fall_i(dclk_fall_i),
        .pd_wr_i(pd_wr_i), .pd_i(pd_i), .touch_i(touch_i),
        .pen_irq_n_o(pen_irq_n_o), .powered_o(powered_o), .ymin_gnd_o(ymin_gnd_o)
    );

    typedef struct {
        string tag;
        logic  pen;
        logic  pow;
        logic  ysw;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    task automatic compare(input string tag, input logic ep, input logic epw, input logic ey);
        n_chk++;
        if (pen_irq_n_o !== ep || powered_o !== epw || ymin_gnd_o !== ey) begin
            n_err++;
            $display("FAIL %s: got pen=%b pow=%b ysw=%b expected pen=%b pow=%b ysw=%b",
                     tag, pen_irq_n_o, powered_o, ymin_gnd_o, ep, epw, ey);
        end
    endtask

    // driver: one clock edge of stimulus, then the outputs expected after it
    task automatic step(input logic s, input logic f, input logic w, input logic [1:0] p,
                        input logic t, input logic ep, input logic epw, input logic ey,
                        input string tag);
        @(negedge clk);
        start_i = s; dclk_fall_i = f; pd_wr_i = w; pd_i = p; touch_i = t;
        q.push_back('{tag, ep, epw, ey});
    endtask

    task automatic rep(input int n, input logic f, input logic t, input logic ep,
                       input logic epw, input logic ey, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, f, 1'b0, 2'b00, t, ep, epw, ey, tag);
    endtask

    // monitor: pops one expected item per edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            compare(e.tag, e.pen, e.pow, e.ysw);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; start_i = 0; dclk_fall_i = 0; pd_wr_i = 0; pd_i = 2'b00; touch_i = 0;
        repeat (3) @(negedge clk);
        compare("R1 in reset", 1'b1, 1'b1, 1'b0);
        rst_n = 1'b1;
        step(0,0,0,2'b00,0, 1,1,0, "R1 after reset");

        // R4/R6: default code 10, short touch then a long one
        rep(TD-1, 0, 1, 1,1,0, "R6 short touch");
        step(0,0,0,2'b00,0, 1,1,0, "R6 early release");
        rep(TD-1, 0, 1, 1,1,0, "R6 counting");
        step(0,0,0,2'b00,1, 0,1,0, "R4 R6 pen low after delay");
        // R11: stray falling edges in idle
        rep(3, 1, 1, 0,1,0, "R11 idle fall ignored");
        step(0,0,0,2'b00,0, 1,1,0, "R6 release");
        rep(TD-1, 0, 1, 1,1,0, "R6 retouch");
        step(0,0,0,2'b00,1, 0,1,0, "R6 pen low again");

        // R7/R9: start with pen low, new code 00 mid conversion
        step(1,0,0,2'b00,1, 0,1,0, "R7 start holds pen");
        rep(WE-1, 1, 1, 0,1,0, "R7 pen held before wake");
        step(0,1,0,2'b00,1, 1,1,0, "R7 R11 pen high on wake");
        step(0,0,1,2'b00,1, 1,1,0, "R9 code write in conversion");
        rep(DE-WE-1, 1, 1, 1,1,0, "R7 no pen during conversion");
        step(0,1,0,2'b00,1, 1,0,1, "R9 R2 end of conversion");
        rep(TD-1, 0, 1, 1,0,1, "R9 count restarts");
        step(0,0,0,2'b00,1, 0,0,1, "R2 R9 pen low in 00");
        step(0,0,0,2'b00,0, 1,0,1, "R2 release");

        // R8/R10: power-up on wake, restart by second start
        step(1,0,0,2'b00,1, 1,0,1, "R8 start keeps sleep");
        rep(5, 0, 1, 1,0,1, "R7 touch masked in command");
        rep(WE-1, 1, 1, 1,0,1, "R8 asleep before wake");
        step(0,1,0,2'b00,0, 1,1,0, "R8 powered on wake");
        rep(6, 1, 0, 1,1,0, "R8 converting");
        step(1,0,0,2'b00,0, 1,1,0, "R10 restart holds power");
        rep(DE-1, 1, 0, 1,1,0, "R10 count restarted");
        step(0,1,0,2'b00,0, 1,0,1, "R10 done after full count");

        // R3: code 01
        step(0,0,1,2'b01,0, 1,0,0, "R3 code 01");
        rep(2*TD, 0, 1, 1,0,0, "R3 touch masked");

        // R5: code 11, then back to 10
        step(0,0,1,2'b11,1, 1,1,0, "R5 code 11");
        rep(2*TD, 0, 1, 1,1,0, "R5 touch masked");
        step(0,0,1,2'b10,1, 1,1,0, "R4 code 10 written");
        rep(TD-1, 0, 1, 1,1,0, "R4 counting");
        step(0,0,0,2'b00,1, 0,1,0, "R4 pen low");
        step(0,0,0,2'b00,0, 1,1,0, "R6 final release");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule